// File: doc/BRIEF.md
# Crystal oscillator startup supervisor

This block turns an external crystal oscillator on and off under software control, and it holds back a "clock stable" indication until a programmable settling time has elapsed. Software uses a small 32-bit register bus to set the enable state, a frequency-range code, a pause/wake word and the startup delay. The oscillator is represented by a tick input: one pulse per oscillator period, present only while the oscillator enable output is high.

The startup delay is programmed in units of 256 oscillator periods. An extra bit multiplies the delay by four. Control values are protected by magic codes. Any write that carries an illegal code is discarded and raises a sticky error flag, which software clears explicitly. Switching the oscillator off or pausing it drops the stable indication at once, and the next start counts the full delay again.

Register word addresses on `addr_i` are: 0 control, 1 status, 2 pause, 3 startup. Reads return data one cycle after the request, together with `rvalid_o`.

Top module: `xosc_supervisor`

## Requirements
- R1: After reset `osc_en_o` and `stable_o` are 0, status reads 0x0000_0000, startup reads 0x0000_00C4, control reads 0x00D1_EAA0 and the pause register reads 0xA5A5_0E0E.
- R2: Writing control with bits 23:12 = 0xFAB and a legal range code raises `osc_en_o` (unless paused). Writing 0xD1E in bits 23:12 lowers it. Status bit 12 mirrors `osc_en_o`, and status bits 11:0 always read 0.
- R3: A control write whose bits 23:12 are neither 0xFAB nor 0xD1E changes nothing and sets the error flag in status bit 24.
- R4: Control bits 11:0 accept only 0xAA0 to 0xAA3, and the accepted code reads back in control bits 11:0. Any other code rejects the entire control write and sets status bit 24.
- R5: With startup bits 13:0 = D and bit 20 = 0, `stable_o` and status bit 31 rise one cycle after the 256·D-th oscillator tick following enable, and not earlier. With D = 0 they rise one cycle after enable.
- R6: With startup bit 20 = 1, the delay becomes 1024·D ticks.
- R7: The error flag stays set until a status write with bit 24 = 1. A status write with bit 24 = 0 leaves it set.
- R8: Writing 0x5A5A_0D0D to the pause register lowers `osc_en_o` and `stable_o` at once. Writing 0xA5A5_0E0E resumes and counts the full delay again. Any other value changes nothing and sets the error flag.
- R9: Disabling drops `stable_o` in the same cycle the write takes effect, and a new enable counts the full delay from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| osc_tick_i | input | 1 | One pulse per oscillator period |
| osc_en_o | output | 1 | Oscillator enable |
| stable_o | output | 1 | Oscillator settled |

## Verification
The startup count is exercised with delays of 0, 256 and 1024 ticks, and the stable output is sampled exactly one cycle before and at the expected rise. This separates an off-by-one in the terminal compare, an ignored multiplier and a counter that is not reloaded. Restarts after a disable and after a pause are each followed by a full-length count, which exposes a counter that resumes from its old value. Illegal enable codes, range codes and pause words are each followed by read-back of the control register and status. This shows that the write was discarded in full and that only the sticky flag changed, and that a clear with bit 24 at 0 does not clear it.

// File: rtl/xosc_pkg.sv
package xosc_pkg;
  localparam int unsigned DLY_W   = 14;
  localparam int unsigned UNIT_SH = 8;   // 256 ticks per delay unit
  localparam int unsigned X4_SH   = 2;
  localparam int unsigned CNT_W   = DLY_W + UNIT_SH + X4_SH;

  localparam logic [11:0] EN_ON    = 12'hFAB;
  localparam logic [11:0] EN_OFF   = 12'hD1E;
  localparam logic [9:0]  FR_BASE  = 10'h2A8; // 0xAA0 >> 2
  localparam logic [31:0] DRM_PAUSE = 32'h5A5A_0D0D;
  localparam logic [31:0] DRM_WAKE  = 32'hA5A5_0E0E;
  localparam logic [DLY_W-1:0] DLY_RST = DLY_W'(14'h00C4);

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_STATUS = 2'd1,
    A_PAUSE  = 2'd2,
    A_START  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/xosc_regs.sv
module xosc_regs
  import xosc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             rvalid_o,
  input  logic             stable_i,
  output logic             osc_en_o,
  output logic             paused_o,
  output logic             bad_o,
  output logic [DLY_W-1:0] delay_o,
  output logic             x4_o
);
  logic             en_q, pause_q, bad_q, x4_q;
  logic [1:0]       fr_q;
  logic [DLY_W-1:0] dly_q;
  logic             wr, rd;
  logic             en_ok, fr_ok, pw_ok;
  logic [31:0]      rmux;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign en_ok = (wdata_i[23:12] == EN_ON) || (wdata_i[23:12] == EN_OFF);
  assign fr_ok = (wdata_i[11:2] == FR_BASE);
  assign pw_ok = (wdata_i == DRM_PAUSE) || (wdata_i == DRM_WAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      bad_q   <= 1'b0;
      fr_q    <= 2'd0;
      dly_q   <= DLY_RST;
      x4_q    <= 1'b0;
    end else if (wr) begin
      unique case (reg_addr_e'(addr_i))
        A_CTRL: begin
          if (en_ok && fr_ok) begin
            en_q <= (wdata_i[23:12] == EN_ON);
            fr_q <= wdata_i[1:0];
          end else begin
            bad_q <= 1'b1;
          end
        end
        A_STATUS: if (wdata_i[24]) bad_q <= 1'b0;
        A_PAUSE: begin
          if (pw_ok) pause_q <= (wdata_i == DRM_PAUSE);
          else       bad_q   <= 1'b1;
        end
        A_START: begin
          dly_q <= wdata_i[DLY_W-1:0];
          x4_q  <= wdata_i[20];
        end
        default: ;
      endcase
    end
  end

  assign osc_en_o = en_q & ~pause_q;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_CTRL:   rmux = {8'h00, en_q ? EN_ON : EN_OFF, FR_BASE, fr_q};
      A_STATUS: rmux = {stable_i, 6'b0, bad_q, 11'b0, osc_en_o, 12'b0};
      A_PAUSE:  rmux = pause_q ? DRM_PAUSE : DRM_WAKE;
      A_START:  rmux = {11'b0, x4_q, 6'b0, dly_q};
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rmux;
    end
  end

  assign paused_o = pause_q;
  assign bad_o    = bad_q;
  assign delay_o  = dly_q;
  assign x4_o     = x4_q;
endmodule

// File: rtl/xosc_startup_ctr.sv
module xosc_startup_ctr
  import xosc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             x4_i,
  output logic             stable_o
);
  logic [CNT_W-1:0] cnt_q, target;
  logic             stab_q;

  always_comb begin
    target = CNT_W'({delay_i, {UNIT_SH{1'b0}}});
    if (x4_i) target = target << X4_SH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      stab_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;   // reload so the next start counts the full delay
      stab_q <= 1'b0;
    end else begin
      if (tick_i && !stab_q && (cnt_q < target)) cnt_q <= cnt_q + 1'b1;
      stab_q <= stab_q | (cnt_q >= target);
    end
  end

  // mask keeps stable low in the very cycle the oscillator is stopped
  assign stable_o = stab_q & run_i;
endmodule

// File: rtl/xosc_supervisor.sv
module xosc_supervisor
  import xosc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  input  logic        osc_tick_i,
  output logic        osc_en_o,
  output logic        stable_o
);
  logic             paused, bad_flag, x4;
  logic [DLY_W-1:0] delay;

  xosc_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .stable_i (stable_o),
    .osc_en_o (osc_en_o),
    .paused_o (paused),
    .bad_o    (bad_flag),
    .delay_o  (delay),
    .x4_o     (x4)
  );

  xosc_startup_ctr i_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (osc_en_o),
    .tick_i   (osc_tick_i),
    .delay_i  (delay),
    .x4_i     (x4),
    .stable_o (stable_o)
  );
endmodule

// File: rtl/xosc_supervisor_chk.sv
module xosc_supervisor_chk
  import xosc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        osc_en_o,
  input logic        stable_o,
  input logic        bad_flag,
  input logic        paused
);
  logic wr_ctrl, wr_stat, wr_pause;
  assign wr_ctrl  = req_i && we_i && (addr_i == 2'd0);
  assign wr_stat  = req_i && we_i && (addr_i == 2'd1);
  assign wr_pause = req_i && we_i && (addr_i == 2'd2);

  a_r5_stable_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stable_o |-> osc_en_o);

  a_r9_restart_not_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !stable_o);

  a_r7_bad_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_flag && !(wr_stat && wdata_i[24])) |=> bad_flag);

  a_r3_bad_en_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[23:12] != EN_ON && wdata_i[23:12] != EN_OFF)
      |=> ($stable(osc_en_o) && bad_flag));

  a_r2_enable_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[23:12] == EN_ON && wdata_i[11:2] == FR_BASE && !paused)
      |=> osc_en_o);

  a_r8_pause_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pause && wdata_i == DRM_PAUSE) |=> (!osc_en_o && !stable_o));
endmodule

bind xosc_supervisor xosc_supervisor_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .osc_en_o (osc_en_o),
  .stable_o (stable_o),
  .bad_flag (bad_flag),
  .paused   (paused)
);

// File: tb/test_xosc_supervisor.sv
`timescale 1ns/1ps
module test_xosc_supervisor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, osc_en, stable;
  logic        tick_run = 1'b0;
  logic        osc_tick;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] PAUSE = 32'h5A5A_0D0D;
  localparam logic [31:0] WAKE  = 32'hA5A5_0E0E;

  always #2 clk = ~clk;  // 250 MHz

  assign osc_tick = tick_run & osc_en;  // oscillator runs only while enabled

  xosc_supervisor i_xosc_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .osc_tick_i(osc_tick), .osc_en_o(osc_en), .stable_o(stable)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wait_stable(input int n, input string tag);
    repeat (n) @(negedge clk);
    chk({31'b0, stable}, 32'd0, {tag, " not yet stable"});
    @(negedge clk);
    chk({31'b0, stable}, 32'd1, {tag, " stable"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick_run = 1'b1;
    // R1 reset state
    chk({31'b0, osc_en}, 32'd0, "R1 osc_en");
    chk({31'b0, stable}, 32'd0, "R1 stable");
    rd(2'd1, 32'h0000_0000, "R1 status");
    rd(2'd3, 32'h0000_00C4, "R1 startup");
    rd(2'd0, 32'h00D1_EAA0, "R1 ctrl");
    rd(2'd2, WAKE, "R1 pause");

    // R2 / R5: enable with 256-tick delay
    wr(2'd3, 32'd1);
    wr(2'd0, 32'h00FA_BAA2);
    chk({31'b0, osc_en}, 32'd1, "R2 osc_en on");
    wait_stable(256, "R5 delay 256");
    rd(2'd1, 32'h8000_1000, "R5 status stable");
    rd(2'd0, 32'h00FA_BAA2, "R4 ctrl readback");

    // R3: illegal enable code
    wr(2'd0, 32'h0012_3AA1);
    chk({31'b0, osc_en}, 32'd1, "R3 osc_en unchanged");
    rd(2'd1, 32'h8100_1000, "R3 bad flag");
    rd(2'd0, 32'h00FA_BAA2, "R3 ctrl unchanged");

    // R7: sticky flag
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, 32'h8100_1000, "R7 zero write keeps flag");
    wr(2'd1, 32'h0100_0000);
    rd(2'd1, 32'h8000_1000, "R7 flag cleared");

    // R4: range code checks
    wr(2'd0, 32'h00FA_BAB0);
    rd(2'd1, 32'h8100_1000, "R4 bad range flagged");
    rd(2'd0, 32'h00FA_BAA2, "R4 bad range rejected");
    wr(2'd1, 32'h0100_0000);
    wr(2'd0, 32'h00FA_BAA3);
    rd(2'd0, 32'h00FA_BAA3, "R4 range AA3 accepted");
    rd(2'd1, 32'h8000_1000, "R4 no flag on legal code");

    // R9: disable drops stable at once
    wr(2'd0, 32'h00D1_EAA3);
    chk({31'b0, osc_en}, 32'd0, "R2 osc_en off");
    chk({31'b0, stable}, 32'd0, "R9 stable dropped");
    rd(2'd1, 32'h0000_0000, "R2 status off");

    // R6: x4 multiplier
    wr(2'd3, 32'h0010_0001);
    wr(2'd0, 32'h00FA_BAA3);
    wait_stable(1024, "R6 delay 1024");

    // R9: restart recounts full delay
    wr(2'd0, 32'h00D1_EAA3);
    wr(2'd0, 32'h00FA_BAA3);
    wait_stable(1024, "R9 full recount");

    // R8: pause and wake
    wr(2'd2, PAUSE);
    chk({31'b0, osc_en}, 32'd0, "R8 paused osc_en");
    chk({31'b0, stable}, 32'd0, "R8 paused stable");
    rd(2'd2, PAUSE, "R8 pause readback");
    rd(2'd1, 32'h0000_0000, "R8 paused status");
    wr(2'd2, WAKE);
    chk({31'b0, osc_en}, 32'd1, "R8 wake osc_en");
    wait_stable(1024, "R8 wake recount");
    wr(2'd2, 32'h0000_DEAD);
    chk({31'b0, osc_en}, 32'd1, "R8 bad word ignored");
    rd(2'd1, 32'h8100_1000, "R8 bad word flagged");
    rd(2'd2, WAKE, "R8 pause state unchanged");

    // R5: zero delay
    wr(2'd1, 32'h0100_0000);
    wr(2'd0, 32'h00D1_EAA0);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'h00FA_BAA0);
    wait_stable(0, "R5 zero delay");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL pending reads: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule